// File: doc/BRIEF.md
# Multichannel Transmit Pulser Switch Controller

This block is the digital front end of a bipolar transmit pulser with a return-to-zero damping switch on each channel. Each channel receives two drive requests: one to pull its output toward the positive rail and one to pull it toward the negative rail. The block turns each pair into three mutually exclusive switch enables: positive rail, negative rail and damp-to-ground. A single output enable can force every switch on every channel open.

The two requests can be used in one of two ways. If a retiming clock toggles on its input, every request is captured on that clock's rising edge, and the switch enables change only at those edges. This aligns all channels to one master clock. If the retiming clock stays high or low, the block works as pass-through decode after a programmable number of system-clock cycles. The block finds out which case applies by synchronising the retiming clock into the system clock and watching for rising edges. Each edge restarts an idle counter.

The caller must toggle the retiming clock at least once before driving any request high. The caller must also return all requests to zero before stopping the retiming clock.

Top module: `pulser_ctrl`

## Requirements
- R1: With `oe` high and both requests of a channel low, only that channel's damp enable is high (switch code {pos,neg,damp} = 001).
- R2: With `oe` high, P=1/N=0 gives only the positive enable (100), and P=0/N=1 gives only the negative enable (010).
- R3: With `oe` high and both requests high, all three enables of the channel are low (000).
- R4: With `oe` low, every enable on every channel is low, in either mode and for any request values.
- R5: In retimed mode the enables change only at a rising edge of `rt_clk`, and they show the requests captured at that edge.
- R6: A rising edge on `rt_clk` sets `retimed` high within three system-clock cycles.
- R7: Once no `rt_clk` rising edge has been seen for `RELEASE_CYC` system cycles, `retimed` returns low. This also applies when `rt_clk` is held high. The enables then follow the requests combinationally.
- R8: An active-low asynchronous reset sets `retimed` low and clears the captured requests to the damping state.
- R9: At no time is more than one of a channel's three enables high.
- R10: Each channel decodes its own request pair, whatever the other channels are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock used for retiming-clock activity detection |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe | input | 1 | Global output enable; low forces all switches open |
| rt_clk | input | 1 | Optional retiming clock; requests are captured on its rising edge |
| p_req | input | NCH | Per-channel positive-rail drive requests |
| n_req | input | NCH | Per-channel negative-rail drive requests |
| sw_pos | output | NCH | Positive-rail switch enables |
| sw_neg | output | NCH | Negative-rail switch enables |
| sw_damp | output | NCH | Damp-to-ground switch enables |
| retimed | output | 1 | High while the block is in retimed (synchronous) mode |

## Verification
On every system-clock cycle the assertions check the following:
- no channel has more than one enable high;
- a low output enable clears everything;
- while `retimed` is low, each channel's enables match the decode of its live requests.

Some behaviours can only be shown by the bench's scenarios, because they depend on timing between the two clocks. These are:
- holding the enables between retiming edges and updating them at an edge;
- entering retimed mode after the first pulses;
- the length of the release interval, including when the retiming clock is held high;
- the effect of a reset in the middle of retimed operation.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

   typedef enum logic [1:0] {
      DRV_DAMP = 2'd0,
      DRV_POS  = 2'd1,
      DRV_NEG  = 2'd2,
      DRV_OFF  = 2'd3
   } drive_e;

   typedef struct packed {
      logic pos;
      logic neg;
      logic damp;
   } sw_t;

   function automatic drive_e classify(input logic p, input logic n);
      drive_e d;
      unique case ({p, n})
         2'b00:   d = DRV_DAMP;
         2'b10:   d = DRV_POS;
         2'b01:   d = DRV_NEG;
         default: d = DRV_OFF;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pulser_pn_decode.sv
module pulser_pn_decode
   import pulser_pkg::*;
(
   input  logic p,
   input  logic n,
   input  logic en,
   output sw_t  sw
);

   always_comb begin
      sw = '0;
      if (en) begin
         unique case (classify(p, n))
            DRV_DAMP: sw.damp = 1'b1;
            DRV_POS:  sw.pos  = 1'b1;
            DRV_NEG:  sw.neg  = 1'b1;
            default:  sw      = '0;
         endcase
      end
   end

endmodule

// File: rtl/pulser_rt_detect.sv
module pulser_rt_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int RELEASE_CYC = 20
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic rt_clk,
   output logic active
);

   localparam int CW = $clog2(RELEASE_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   rise;
   logic [CW-1:0]          idle_cnt;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rt_clk};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         active   <= 1'b0;
      end else if (rise) begin
         idle_cnt <= CW'(RELEASE_CYC);
         active   <= 1'b1;
      end else if (idle_cnt != '0) begin
         idle_cnt <= idle_cnt - 1'b1;
         if (idle_cnt == CW'(1)) active <= 1'b0;
      end
   end

endmodule

// File: rtl/pulser_retime.sv
module pulser_retime #(
   parameter int NCH = 8
) (
   input  logic           rt_clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] p_in,
   input  logic [NCH-1:0] n_in,
   output logic [NCH-1:0] p_q,
   output logic [NCH-1:0] n_q
);

   always_ff @(posedge rt_clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= '0;
         n_q <= '0;
      end else begin
         p_q <= p_in;
         n_q <= n_in;
      end
   end

endmodule

// File: rtl/pulser_ctrl.sv
module pulser_ctrl
   import pulser_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int RELEASE_CYC = 20,
   parameter int SYNC_STAGES = 2,
   parameter bit RETIME_EN   = 1'b1
) (
   input  logic           clk_sys,
   input  logic           rst_n,
   input  logic           oe,
   input  logic           rt_clk,
   input  logic [NCH-1:0] p_req,
   input  logic [NCH-1:0] n_req,
   output logic [NCH-1:0] sw_pos,
   output logic [NCH-1:0] sw_neg,
   output logic [NCH-1:0] sw_damp,
   output logic           retimed
);

   if (NCH < 1) begin : g_bad_nch
      $error("pulser_ctrl: NCH must be at least 1");
   end
   if (RELEASE_CYC < 2) begin : g_bad_rel
      $error("pulser_ctrl: RELEASE_CYC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pulser_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NCH-1:0] p_sel, n_sel;

   if (RETIME_EN) begin : g_retime
      logic [NCH-1:0] p_q, n_q;

      pulser_rt_detect #(
         .SYNC_STAGES (SYNC_STAGES),
         .RELEASE_CYC (RELEASE_CYC)
      ) u_detect (
         .clk_sys (clk_sys),
         .rst_n   (rst_n),
         .rt_clk  (rt_clk),
         .active  (retimed)
      );

      pulser_retime #(.NCH(NCH)) u_regs (
         .rt_clk (rt_clk),
         .rst_n  (rst_n),
         .p_in   (p_req),
         .n_in   (n_req),
         .p_q    (p_q),
         .n_q    (n_q)
      );

      assign p_sel = retimed ? p_q : p_req;
      assign n_sel = retimed ? n_q : n_req;
   end else begin : g_passthru
      assign retimed = 1'b0;
      assign p_sel   = p_req;
      assign n_sel   = n_req;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      sw_t sw;
      pulser_pn_decode u_dec (
         .p  (p_sel[i]),
         .n  (n_sel[i]),
         .en (oe),
         .sw (sw)
      );
      assign sw_pos[i]  = sw.pos;
      assign sw_neg[i]  = sw.neg;
      assign sw_damp[i] = sw.damp;
   end

endmodule

// File: rtl/pulser_ctrl_chk.sv
module pulser_ctrl_chk #(
   parameter int NCH = 8
) (
   input logic           clk_sys,
   input logic           rst_n,
   input logic           oe,
   input logic [NCH-1:0] p_req,
   input logic [NCH-1:0] n_req,
   input logic [NCH-1:0] sw_pos,
   input logic [NCH-1:0] sw_neg,
   input logic [NCH-1:0] sw_damp,
   input logic           retimed
);

   // R4: a low enable leaves every switch open
   p_oe_off_r4: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !oe |-> (sw_pos == '0 && sw_neg == '0 && sw_damp == '0));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      // R9: never two switches of one channel at once
      p_onehot_r9: assert property (@(posedge clk_sys) disable iff (!rst_n)
         $onehot0({sw_pos[i], sw_neg[i], sw_damp[i]}));

      // R1: pass-through, both requests low -> damping
      p_async_damp_r1: assert property (@(posedge clk_sys) disable iff (!rst_n)
         (!retimed && oe && !p_req[i] && !n_req[i]) |-> sw_damp[i]);

      // R2: pass-through, positive request alone -> positive rail
      p_async_pos_r2: assert property (@(posedge clk_sys) disable iff (!rst_n)
         (!retimed && oe && p_req[i] && !n_req[i]) |-> sw_pos[i]);

      // R2: pass-through, negative request alone -> negative rail
      p_async_neg_r2: assert property (@(posedge clk_sys) disable iff (!rst_n)
         (!retimed && oe && !p_req[i] && n_req[i]) |-> sw_neg[i]);

      // R3: pass-through, both requests -> all open
      p_async_off_r3: assert property (@(posedge clk_sys) disable iff (!rst_n)
         (!retimed && p_req[i] && n_req[i]) |-> !(sw_pos[i] || sw_neg[i] || sw_damp[i]));
   end

endmodule

bind pulser_ctrl pulser_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk_sys (clk_sys),
   .rst_n   (rst_n),
   .oe      (oe),
   .p_req   (p_req),
   .n_req   (n_req),
   .sw_pos  (sw_pos),
   .sw_neg  (sw_neg),
   .sw_damp (sw_damp),
   .retimed (retimed)
);

// File: tb/pulser_ctrl_test.sv
module pulser_ctrl_test;

   localparam int NCH = 8;
   localparam int REL = 20;

   logic           clk_sys = 1'b0;
   logic           rst_n   = 1'b0;
   logic           oe      = 1'b1;
   logic           rt_clk  = 1'b0;
   logic [NCH-1:0] p_req   = '0;
   logic [NCH-1:0] n_req   = '0;
   logic [NCH-1:0] sw_pos, sw_neg, sw_damp;
   logic           retimed;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   pulser_ctrl #(.NCH(NCH), .RELEASE_CYC(REL)) uut (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .oe      (oe),
      .rt_clk  (rt_clk),
      .p_req   (p_req),
      .n_req   (n_req),
      .sw_pos  (sw_pos),
      .sw_neg  (sw_neg),
      .sw_damp (sw_damp),
      .retimed (retimed)
   );

   always #10 clk_sys = ~clk_sys;

   // expected code {pos,neg,damp}
   function automatic logic [2:0] expect_of(logic p, logic n, logic en);
      if (!en)        return 3'b000;
      if (p && n)     return 3'b000;
      if (p)          return 3'b100;
      if (n)          return 3'b010;
      return 3'b001;
   endfunction

   task automatic chk_all(logic [NCH-1:0] pv, logic [NCH-1:0] nv, string tag);
      for (int ch = 0; ch < NCH; ch++) begin
         logic [2:0] act = {sw_pos[ch], sw_neg[ch], sw_damp[ch]};
         logic [2:0] exp = expect_of(pv[ch], nv[ch], oe);
         n_chk++;
         if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: got %b expected %b", tag, ch, act, exp);
         end
      end
   endtask

   task automatic chk_mode(logic exp, string tag);
      n_chk++;
      if (retimed !== exp) begin
         n_bad++;
         $display("FAIL %s retimed: got %b expected %b", tag, retimed, exp);
      end
   endtask

   task automatic align();
      @(posedge clk_sys);
      #5;
   endtask

   task automatic wait_cyc(int n);
      #(20 * n);
   endtask

   // one retiming pulse of 100 ns; optional check just after the rising edge
   task automatic pulse(bit do_chk, logic [NCH-1:0] pv, logic [NCH-1:0] nv, string tag);
      rt_clk = 1'b1;
      #1;
      if (do_chk) chk_all(pv, nv, tag);
      #49;
      rt_clk = 1'b0;
      #50;
   endtask

   task automatic t_reset();
      #15;
      chk_mode(1'b0, "R8 reset mode");
      chk_all('0, '0, "R8/R1 reset damping");
      rst_n = 1'b1;
      align();
   endtask

   task automatic t_async_decode();
      p_req = '0;        n_req = '0;        #1; chk_all(p_req, n_req, "R1 all damp");
      p_req = '1;        n_req = '0;        #1; chk_all(p_req, n_req, "R2 all pos");
      p_req = '0;        n_req = '1;        #1; chk_all(p_req, n_req, "R2 all neg");
      p_req = '1;        n_req = '1;        #1; chk_all(p_req, n_req, "R3 all off");
      p_req = 8'b1010_1010; n_req = 8'b1100_1100; #1; chk_all(p_req, n_req, "R10 mixed a");
      p_req = 8'b0110_0001; n_req = 8'b0011_1000; #1; chk_all(p_req, n_req, "R10 mixed b");
      p_req = '0; n_req = '0;
      align();
   endtask

   task automatic t_oe_off();
      oe = 1'b0;
      p_req = 8'b1111_0000; n_req = 8'b0011_1100; #1; chk_all(p_req, n_req, "R4 oe low pattern");
      p_req = '0; n_req = '0; #1; chk_all(p_req, n_req, "R4 oe low zeros");
      oe = 1'b1; #1; chk_all(p_req, n_req, "R4 oe back");
      align();
   endtask

   task automatic t_sync();
      logic [NCH-1:0] held_p, held_n;
      for (int k = 0; k < 3; k++) pulse(1'b0, '0, '0, "");
      chk_mode(1'b1, "R6 enter retimed");
      held_p = '0; held_n = '0;
      p_req = '1; n_req = '0;
      #1; chk_all(held_p, held_n, "R5 hold before edge");
      #9;
      pulse(1'b1, p_req, n_req, "R5 capture pos");
      held_p = p_req; held_n = n_req;
      p_req = 8'b1001_0110; n_req = 8'b0101_0011;
      #1; chk_all(held_p, held_n, "R5 hold between edges");
      #9;
      pulse(1'b1, p_req, n_req, "R5 capture mixed R10");
      held_p = p_req; held_n = n_req;
      oe = 1'b0; #1; chk_all(held_p, held_n, "R4 oe low retimed");
      oe = 1'b1; #9;
      p_req = '0; n_req = '0;
      pulse(1'b1, '0, '0, "R5 capture zeros");
      chk_mode(1'b1, "R6 still retimed");
   endtask

   task automatic t_release();
      wait_cyc(10);
      chk_mode(1'b1, "R7 before release");
      wait_cyc(15);
      chk_mode(1'b0, "R7 after release");
      p_req = 8'b0000_1111; n_req = 8'b0011_0000;
      #1; chk_all(p_req, n_req, "R7 follows after release");
      p_req = '0; n_req = '0;
      align();
   endtask

   task automatic t_held_high();
      for (int k = 0; k < 2; k++) pulse(1'b0, '0, '0, "");
      chk_mode(1'b1, "R6 re-enter");
      rt_clk = 1'b1;
      wait_cyc(REL + 6);
      chk_mode(1'b0, "R7 held high release");
      p_req = 8'b1111_1111; n_req = 8'b1000_0001;
      #1; chk_all(p_req, n_req, "R7 held high follows");
      p_req = '0; n_req = '0;
      #4; rt_clk = 1'b0;
      align();
   endtask

   task automatic t_reset_mid();
      for (int k = 0; k < 2; k++) pulse(1'b0, '0, '0, "");
      p_req = '1; n_req = '0;
      #10;
      pulse(1'b1, p_req, n_req, "R5 capture before reset");
      rst_n = 1'b0;
      p_req = '0;
      #1;
      chk_mode(1'b0, "R8 mid reset mode");
      chk_all('0, '0, "R8 mid reset damping");
      align();
      rst_n = 1'b1;
      align();
   endtask

   initial begin
      t_reset();
      t_async_decode();
      t_oe_off();
      t_sync();
      t_release();
      t_held_high();
      t_reset_mid();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule